// File: doc/BRIEF.md
# Auto-Incrementing Packet Buffer Window

This block gives a byte-wide host port access to a packet buffer of four pages, each 2048 bytes. The host programs a 16-bit pointer, one byte at a time. The pointer names a byte offset inside a page and picks which page is used: either the page the host has selected or the page at the head of the receive queue. A four-byte data window then reads or writes that byte.

The pointer has two modes. In auto-increment mode, every data-window access moves the offset forward by one. A driver can therefore stream a whole frame through any window address. In lane mode, the pointer stays put, and the two low address bits choose one of four consecutive bytes, so a driver can touch a small field at random.

The packet allocation logic and the network side of the design are outside this block. They provide the host-selected page number and the receive-queue head page as plain inputs.

Top module: `pkt_buf_window`

## Requirements
- R1: After reset the pointer is zero, `bus_rvalid` is low, and both pointer bytes read back as 0x00.
- R2: A write to address 6 sets pointer bits 7:0, and a write to address 7 sets pointer bits 15:8. Each write leaves the other half unchanged. A read of address 6 returns bits 7:0 exactly.
- R3: A read of address 7 returns pointer bits 15:8 with bit 3 of that byte forced to zero (mask 0xF7).
- R4: Pointer bit 15 chooses the page for every data-window access. When it is set, the page is `rxq_page`. When it is clear, the page is `host_page`.
- R5: When pointer bit 14 is set, each data-window access (addresses 8 to 11, read or write) uses pointer bits 10:0 as the offset. The access then adds one to bits 10:0, wrapping from 2047 to 0, and leaves bits 15:11 unchanged.
- R6: When pointer bit 14 is clear, the offset is pointer bits 10:0 plus `bus_addr[1:0]`, wrapping within 11 bits inside the same page. The pointer does not change.
- R7: A read returns its byte on `bus_rdata` with `bus_rvalid` high in the cycle after the read strobe. A write stores its byte so that a read in the very next cycle returns it. A cycle with both strobes high is a write only. `bus_rvalid` is low after any cycle with no read.
- R8: Addresses other than 6 to 11 read as 0x00. Writes to them change neither the pointer nor the buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 4 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, one cycle after the read |
| bus_rvalid | output | 1 | High when `bus_rdata` holds a read result |
| host_page | input | 2 | Page selected by the host |
| rxq_page | input | 2 | Page at the head of the receive queue |

## Verification
Every read result, whether it comes from the buffer or from the pointer, appears exactly one clock after the strobe. The bench drives each access at a falling edge and samples `bus_rdata` and `bus_rvalid` at the next falling edge, which falls inside that one-cycle window. A pointer change caused by an access takes effect at the same rising edge. A pointer read issued in the next cycle therefore shows the updated value, and the bench predicts it that way. Buffer contents follow an arithmetic pattern of page and offset, written by sweeping every byte of all four pages, so every read has a computed expected value.

// File: rtl/pkt_buf_window.sv
module pkt_buf_window #(
  parameter int PAGES    = 4,
  parameter int OFF_W    = 11,
  parameter int ADDR_W   = 4,
  parameter int PTR_LO   = 6,
  parameter int PTR_HI   = 7,
  parameter int WIN_BASE = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [ADDR_W-1:0]        bus_addr,
  input  logic                     bus_wr,
  input  logic                     bus_rd,
  input  logic [7:0]               bus_wdata,
  output logic [7:0]               bus_rdata,
  output logic                     bus_rvalid,
  input  logic [$clog2(PAGES)-1:0] host_page,
  input  logic [$clog2(PAGES)-1:0] rxq_page
);
  localparam int PAGE_W  = $clog2(PAGES);
  localparam int BYTE_AW = PAGE_W + OFF_W;
  localparam int WORD_AW = BYTE_AW - 2;
  localparam int WORDS   = 1 << WORD_AW;

  logic [15:0]        ptr;
  logic [3:0][7:0]    mem [WORDS];
  logic [3:0][7:0]    rword;
  logic [1:0]         rlane;
  logic               rfrom_mem;
  logic [7:0]         rreg;

  logic               win_hit, rd_any, rd_win, wr_win, step;
  logic [PAGE_W-1:0]  page_sel;
  logic [OFF_W-1:0]   off;
  logic [BYTE_AW-1:0] byte_addr;
  logic [7:0]         reg_byte;

  assign win_hit   = bus_addr[ADDR_W-1:2] == (ADDR_W-2)'(WIN_BASE >> 2);
  assign rd_any    = bus_rd & ~bus_wr;
  assign rd_win    = rd_any & win_hit;
  assign wr_win    = bus_wr & win_hit;
  assign step      = (rd_win | wr_win) & ptr[14];
  assign page_sel  = ptr[15] ? rxq_page : host_page;
  assign off       = ptr[OFF_W-1:0] + (ptr[14] ? OFF_W'(0) : OFF_W'(bus_addr[1:0]));
  assign byte_addr = {page_sel, off};

  always_comb begin
    reg_byte = 8'h00;
    if (bus_addr == ADDR_W'(PTR_LO)) reg_byte = ptr[7:0];
    else if (bus_addr == ADDR_W'(PTR_HI)) reg_byte = ptr[15:8] & 8'hF7;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ptr <= '0;
    else if (bus_wr && bus_addr == ADDR_W'(PTR_LO)) ptr[7:0] <= bus_wdata;
    else if (bus_wr && bus_addr == ADDR_W'(PTR_HI)) ptr[15:8] <= bus_wdata;
    else if (step) ptr[OFF_W-1:0] <= ptr[OFF_W-1:0] + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (wr_win) mem[byte_addr[BYTE_AW-1:2]][byte_addr[1:0]] <= bus_wdata;
    if (rd_win) rword <= mem[byte_addr[BYTE_AW-1:2]];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rvalid <= 1'b0;
      rfrom_mem  <= 1'b0;
      rlane      <= '0;
      rreg       <= '0;
    end else begin
      bus_rvalid <= rd_any;
      rfrom_mem  <= rd_win;
      rlane      <= byte_addr[1:0];
      rreg       <= reg_byte;
    end
  end

  assign bus_rdata = rfrom_mem ? rword[rlane] : rreg;

  a_r2_low_half: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'(PTR_LO)) |=>
      (ptr[7:0] == $past(bus_wdata) && ptr[15:8] == $past(ptr[15:8])));
  a_r2_high_half: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'(PTR_HI)) |=>
      (ptr[15:8] == $past(bus_wdata) && ptr[7:0] == $past(ptr[7:0])));
  a_r3_hi_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !bus_wr && bus_addr == ADDR_W'(PTR_HI)) |=> (bus_rdata[3] == 1'b0));
  a_r5_autoinc: assert property (@(posedge clk) disable iff (!rst_n)
    ((bus_rd || bus_wr) && win_hit && ptr[14]) |=>
      (ptr[OFF_W-1:0] == OFF_W'($past(ptr[OFF_W-1:0]) + 1'b1) && $stable(ptr[15:OFF_W])));
  a_r6_lane_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ((bus_rd || bus_wr) && win_hit && !ptr[14]) |=> $stable(ptr));
  a_r7_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !bus_wr) |=> bus_rvalid);
  a_r7_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_rd && !bus_wr) |=> !bus_rvalid);
  a_r8_other_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !win_hit && bus_addr != ADDR_W'(PTR_LO) && bus_addr != ADDR_W'(PTR_HI))
      |=> $stable(ptr));
endmodule

// File: tb/pkt_buf_window_bench.sv
module pkt_buf_window_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] bus_addr = '0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       bus_rvalid;
  logic [1:0] host_page = '0, rxq_page = '0;
  int checks = 0, fails = 0;
  bit done = 1'b0;
  logic [7:0] r;
  logic       v;

  always #2.5 clk = ~clk;

  pkt_buf_window u_pkt_buf_window (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .host_page(host_page), .rxq_page(rxq_page));

  function automatic logic [7:0] pat(input int pg, input int off);
    return 8'((pg * 61) + (off * 7) + (off >> 8));
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic acc(input bit wr, input logic [3:0] a, input logic [7:0] d,
                     output logic [7:0] rd_o, output logic vd_o);
    bus_addr = a; bus_wr = wr; bus_rd = !wr; bus_wdata = d;
    @(negedge clk);
    rd_o = bus_rdata; vd_o = bus_rvalid;
  endtask

  task automatic idle();
    bus_wr = 1'b0; bus_rd = 1'b0;
    @(negedge clk);
  endtask

  task automatic set_ptr(input logic [15:0] p);
    logic [7:0] x; logic y;
    acc(1'b1, 4'd6, p[7:0], x, y);
    acc(1'b1, 4'd7, p[15:8], x, y);
  endtask

  task automatic rd_chk(input logic [3:0] a, input logic [7:0] exp, input string req);
    logic [7:0] x; logic y;
    acc(1'b0, a, 8'h00, x, y);
    check(y === 1'b1 && x === exp, req, x, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(bus_rvalid === 1'b0, "R1 rvalid", bus_rvalid, 0);
    rst_n = 1'b1;
    rd_chk(4'd6, 8'h00, "R1 ptr lo");
    rd_chk(4'd7, 8'h00, "R1 ptr hi");

    acc(1'b1, 4'd6, 8'hA5, r, v);
    check(v === 1'b0, "R7 no valid after write", v, 0);
    rd_chk(4'd6, 8'hA5, "R2 lo written");
    rd_chk(4'd7, 8'h00, "R2 hi untouched");
    acc(1'b1, 4'd7, 8'h3C, r, v);
    rd_chk(4'd6, 8'hA5, "R2 lo kept");
    rd_chk(4'd7, 8'h34, "R3 hi masked");
    acc(1'b1, 4'd7, 8'hFF, r, v);
    rd_chk(4'd7, 8'hF7, "R3 hi all ones");

    for (int pg = 0; pg < 4; pg++) begin
      host_page = 2'(pg);
      rxq_page  = 2'(3 - pg);
      set_ptr(16'h4000);
      for (int i = 0; i < 2048; i++) acc(1'b1, 4'(8 + (i % 4)), pat(pg, i), r, v);
      rd_chk(4'd6, 8'h00, "R5 wrap lo");
      rd_chk(4'd7, 8'h40, "R5 wrap hi");
    end

    for (int pg = 0; pg < 4; pg++) begin
      rxq_page  = 2'(pg);
      host_page = 2'((pg + 1) % 4);
      set_ptr(16'hC000);
      for (int i = 0; i < 2048; i++) rd_chk(4'(8 + (i % 3)), pat(pg, i), "R4 R5 sweep");
      rd_chk(4'd7, 8'hC0, "R5 bits kept");
    end

    host_page = 2'd2; rxq_page = 2'd0;
    set_ptr(16'h0010);
    for (int k = 0; k < 4; k++) rd_chk(4'(8 + k), pat(2, 16 + k), "R6 lanes");
    acc(1'b1, 4'd10, 8'h5A, r, v);
    rd_chk(4'd10, 8'h5A, "R7 write then read");
    rd_chk(4'd9, pat(2, 17), "R6 neighbour");
    rd_chk(4'd6, 8'h10, "R6 ptr held");

    set_ptr(16'h07FF);
    rd_chk(4'd11, pat(2, 2), "R6 lane wrap");
    rd_chk(4'd8, pat(2, 2047), "R6 lane top");
    rd_chk(4'd6, 8'hFF, "R6 ptr lo held");
    rd_chk(4'd7, 8'h07, "R6 ptr hi held");

    host_page = 2'd3; rxq_page = 2'd0;
    set_ptr(16'h0005);
    rd_chk(4'd8, pat(3, 5), "R4 host page");
    set_ptr(16'h8005);
    rd_chk(4'd8, pat(0, 5), "R4 rx page");

    rxq_page = 2'd1;
    set_ptr(16'hF7FE);
    rd_chk(4'd8, pat(1, 2046), "R5 read step a");
    rd_chk(4'd8, pat(1, 2047), "R5 read step b");
    rd_chk(4'd6, 8'h00, "R5 lo wrapped");
    rd_chk(4'd7, 8'hF0, "R5 upper kept");

    set_ptr(16'h0123);
    acc(1'b1, 4'd0, 8'hFF, r, v);
    acc(1'b1, 4'd13, 8'hFF, r, v);
    rd_chk(4'd6, 8'h23, "R8 ptr lo unchanged");
    rd_chk(4'd7, 8'h01, "R8 ptr hi unchanged");
    rd_chk(4'd0, 8'h00, "R8 read zero");
    rd_chk(4'd13, 8'h00, "R8 read zero 13");
    host_page = 2'd0;
    set_ptr(16'h0000);
    rd_chk(4'd8, pat(0, 0), "R8 buffer untouched");

    idle();
    check(bus_rvalid === 1'b0, "R7 idle", bus_rvalid, 0);
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule